// File: doc/BRIEF.md
# Sixteen-Channel Staged PWM Dimmer

This block drives sixteen LED channels from one shared 8-bit sawtooth counter. Each channel owns an 8-bit duty value. A channel's drive enable is high while the counter is below that value, so each 256-cycle period gives an on-fraction of value/256. The largest value, FFh, therefore leaves the output low for one cycle in every period.

Software reaches the block through a simple write port: an address, a data byte and a one-cycle write strobe. Duty values are double-buffered. Writes land in a shadow set. A write of any byte to the update address marks the shadow set for transfer. All sixteen active values are replaced together at the next counter wrap, so no period is ever cut short or stretched.

Several gates sit between the comparators and the pins:
- a per-channel on/off mask;
- a software run bit;
- an active-low hardware shutdown input;
- an ownership mask that hands the upper eight channels to general-purpose I/O and removes them from PWM driving.

No gate clears any stored value.

Top module: `pwm_dimmer16`

## Requirements
- R1: After reset all outputs are low, every duty value (shadow and active) is 00h, both on/off bytes are FFh, the run bit is 1 and the I/O ownership byte is 00h.
- R2: A channel with active duty V is high for exactly V of any 256 consecutive cycles. It is high in a cycle exactly when the shared counter is below V, so 00h never drives and FFh drives 255 of 256 cycles.
- R3: The duty registers sit at 10h–1Fh in reverse channel order. Address 10h+k holds channel 16−k, so 10h is channel 16 (drive bit 15) and 1Fh is channel 1 (drive bit 0).
- R4: Duty writes change only the shadow set; outputs keep the old duty until a write of any data byte to address B0h.
- R5: After an update write, the shadow values become active in the first cycle in which the counter has wrapped from FFh to 00h. Until that cycle the old values stay in force.
- R6: Address 02h bit k gates channel k+1 and address 01h bit k gates channel k+9; a 0 bit forces that channel low.
- R7: Address 00h bit 7 is the run bit: 0 forces every output low, 1 restores driving with all stored values unchanged.
- R8: While the hardware shutdown input is low every output is low; when it returns high the previous duties resume unchanged.
- R9: Address 04h bit k set to 1 gives channel k+9 to general-purpose I/O and holds its drive low; bit value 0 returns it to PWM driving.
- R10: Writes to any address not listed in R3, R4, R6, R7 or R9 change no output and do not start a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances once per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per register write |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Register data of the write |
| shutdown_n | input | 1 | Hardware shutdown, active low, forces all outputs off |
| drive | output | 16 | Drive enables, bit 0 is channel 1 |

## Verification
A register write presented in one cycle is captured at the next rising edge. The outputs are decoded directly from registered state, so the effect of the write is visible from that edge on. The hardware shutdown input gates the outputs with no register delay. A duty transfer lands on the edge that takes the counter from FFh to 00h, which is at most 256 cycles after the update write. The bench therefore keeps its own model of the counter value, samples on falling edges, and checks the old value at counter FFh and the new one at 00h. All duty checks count high cycles over a full 256-cycle window that starts after the transfer. That count does not depend on the phase of the counter.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;

    localparam int CH_N    = 16;
    localparam int DUTY_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int HALF_N  = CH_N / 2;
    localparam int GPIO_N  = CH_N - HALF_N;
    localparam int RUN_BIT = 7;

    typedef logic [DUTY_W-1:0] duty_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t ADDR_CFG    = 8'h00;
    localparam addr_t ADDR_EN_HI  = 8'h01;
    localparam addr_t ADDR_EN_LO  = 8'h02;
    localparam addr_t ADDR_IO_OWN = 8'h04;
    localparam addr_t ADDR_DUTY   = 8'h10;
    localparam addr_t ADDR_UPDATE = 8'hB0;

    typedef struct packed {
        logic                  run;
        logic [CH_N-1:0]       en;
        logic [GPIO_N-1:0]     io_own;
        duty_t [CH_N-1:0]      shadow;
    } regs_t;

    typedef struct packed {
        duty_t                 cnt;
        logic                  pending;
        duty_t [CH_N-1:0]      active;
    } bank_t;

endpackage

// File: rtl/pwm16_regfile.sv
module pwm16_regfile
    import pwm16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  addr_t             wr_addr,
    input  logic [DUTY_W-1:0] wr_data,
    output logic              run,
    output logic [CH_N-1:0]   en,
    output logic [GPIO_N-1:0] io_own,
    output duty_t [CH_N-1:0]  shadow,
    output logic              upd_strobe
);

    localparam regs_t RESET_VAL = '{run: 1'b1, en: '1, io_own: '0, shadow: '0};

    regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        upd_strobe = 1'b0;
        if (wr_en) begin
            if (wr_addr == ADDR_CFG)    r_d.run = wr_data[RUN_BIT];
            if (wr_addr == ADDR_EN_HI)  r_d.en[CH_N-1:HALF_N] = wr_data[CH_N-HALF_N-1:0];
            if (wr_addr == ADDR_EN_LO)  r_d.en[HALF_N-1:0]    = wr_data[HALF_N-1:0];
            if (wr_addr == ADDR_IO_OWN) r_d.io_own = wr_data[GPIO_N-1:0];
            if (wr_addr == ADDR_UPDATE) upd_strobe = 1'b1;
            for (int i = 0; i < CH_N; i++) begin
                if (wr_addr == ADDR_W'(int'(ADDR_DUTY) + CH_N - 1 - i))
                    r_d.shadow[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign run    = r_q.run;
    assign en     = r_q.en;
    assign io_own = r_q.io_own;
    assign shadow = r_q.shadow;

endmodule

// File: rtl/pwm16_bank.sv
module pwm16_bank
    import pwm16_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_strobe,
    input  duty_t [CH_N-1:0] shadow,
    output duty_t            cnt,
    output logic             pending,
    output duty_t [CH_N-1:0] active
);

    bank_t b_d, b_q;
    logic  wrap;

    always_comb begin
        b_d         = b_q;
        wrap        = (b_q.cnt == '1);
        b_d.cnt     = b_q.cnt + 1'b1;
        b_d.pending = upd_strobe | (b_q.pending & ~wrap);
        if (wrap && b_q.pending) b_d.active = shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign cnt     = b_q.cnt;
    assign pending = b_q.pending;
    assign active  = b_q.active;

endmodule

// File: rtl/pwm16_gate.sv
module pwm16_gate
    import pwm16_pkg::*;
(
    input  duty_t            cnt,
    input  duty_t [CH_N-1:0] active,
    input  logic             run,
    input  logic             shutdown_n,
    input  logic [CH_N-1:0]  en,
    input  logic [CH_N-1:0]  own_full,
    output logic [CH_N-1:0]  drive
);

    logic global_on;
    assign global_on = run & shutdown_n;

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        logic below;
        assign below    = (cnt < active[g]);
        assign drive[g] = global_on & en[g] & ~own_full[g] & below;
    end

endmodule

// File: rtl/pwm_dimmer16.sv
module pwm_dimmer16
    import pwm16_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        shutdown_n,
    output logic [15:0] drive
);

    logic              run;
    logic [CH_N-1:0]   en;
    logic [GPIO_N-1:0] io_own;
    logic [CH_N-1:0]   own_full;
    duty_t [CH_N-1:0]  shadow;
    duty_t [CH_N-1:0]  active;
    duty_t             cnt;
    logic              pending;
    logic              upd_strobe;

    assign own_full = {io_own, {(CH_N-GPIO_N){1'b0}}};

    pwm16_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .run        (run),
        .en         (en),
        .io_own     (io_own),
        .shadow     (shadow),
        .upd_strobe (upd_strobe)
    );

    pwm16_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_strobe (upd_strobe),
        .shadow     (shadow),
        .cnt        (cnt),
        .pending    (pending),
        .active     (active)
    );

    pwm16_gate u_gate (
        .cnt        (cnt),
        .active     (active),
        .run        (run),
        .shutdown_n (shutdown_n),
        .en         (en),
        .own_full   (own_full),
        .drive      (drive)
    );

endmodule

// File: rtl/pwm16_checker.sv
module pwm16_checker
    import pwm16_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             shutdown_n,
    input logic [CH_N-1:0]  drive,
    input logic             run,
    input logic [CH_N-1:0]  en,
    input logic [CH_N-1:0]  own_full,
    input duty_t            cnt,
    input logic             pending,
    input duty_t [CH_N-1:0] active
);

    assert_active_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> ($past(cnt) == '1 && $past(pending)))
        else $error("active set changed away from a wrap");

    assert_active_needs_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> $past(pending))
        else $error("active set changed with no update pending");

    assert_sw_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (drive == '0))
        else $error("output driven while run bit is clear");

    assert_hw_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !shutdown_n |-> (drive == '0))
        else $error("output driven during hardware shutdown");

    assert_mask_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive & ~en) == '0)
        else $error("disabled channel driven");

    assert_io_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drive & own_full) == '0)
        else $error("I/O-owned channel driven");

    assert_zero_at_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1) |-> (drive == '0 || active != '0))
        else $error("output high with every duty at zero");

endmodule

bind pwm_dimmer16 pwm16_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shutdown_n (shutdown_n),
    .drive      (drive),
    .run        (run),
    .en         (en),
    .own_full   (own_full),
    .cnt        (cnt),
    .pending    (pending),
    .active     (active)
);

// File: tb/sim_pwm_dimmer16.sv
module sim_pwm_dimmer16;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        shutdown_n = 1'b1;
    logic [15:0] drive;

    int errs = 0;
    int checks = 0;
    logic [7:0] tb_cnt;

    int        duty_m [16];
    int        shadow_m [16];
    logic [15:0] en_m = 16'hFFFF;
    logic [7:0]  own_m = 8'h00;
    bit          run_m = 1'b1;
    bit          hw_m = 1'b1;

    pwm_dimmer16 u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .shutdown_n(shutdown_n), .drive(drive)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // counter model: cleared by reset, one step per edge (R2, R5)
    always @(posedge clk or negedge rst_n)
        if (!rst_n) tb_cnt <= '0;
        else        tb_cnt <= tb_cnt + 8'd1;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_count(int i);
        bit owned = (i >= 8) && own_m[i-8];
        if (run_m && hw_m && en_m[i] && !owned) return duty_m[i];
        return 0;
    endfunction

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_duty(int ch, logic [7:0] v);
        wr(8'(8'h10 + 16 - ch), v);
        shadow_m[ch-1] = v;
    endtask

    task automatic do_update(logic [7:0] d);
        wr(8'hB0, d);
        do @(negedge clk); while (tb_cnt != 8'd0);
        for (int i = 0; i < 16; i++) duty_m[i] = shadow_m[i];
    endtask

    task automatic measure_all(string tag);
        int cnts [16];
        for (int i = 0; i < 16; i++) cnts[i] = 0;
        for (int c = 0; c < 256; c++) begin
            @(negedge clk);
            for (int i = 0; i < 16; i++) if (drive[i]) cnts[i]++;
        end
        for (int i = 0; i < 16; i++)
            check(cnts[i] == exp_count(i), $sformatf("%s ch%0d", tag, i+1),
                  cnts[i], exp_count(i));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(drive == 16'h0, "R1 drive after reset", int'(drive), 0);
        measure_all("R1 reset duty");
    endtask

    task automatic t_duty_map();
        wr_duty(1, 8'h80);
        wr_duty(16, 8'hFF);
        wr_duty(2, 8'h01);
        wr_duty(9, 8'h40);
        wr_duty(8, 8'hC3);
        do_update(8'h00);
        measure_all("R2 R3 duty map");
    endtask

    task automatic t_shadow();
        wr_duty(1, 8'h20);
        measure_all("R4 shadow held");
        do_update(8'h5A);
        measure_all("R4 after update");
    endtask

    task automatic t_wrap();
        wr_duty(3, 8'h10);
        wr(8'hB0, 8'hFF);
        while (tb_cnt != 8'hFF) @(negedge clk);
        check(drive[2] == 1'b0, "R5 ch3 before wrap", int'(drive[2]), 0);
        @(negedge clk);
        check(drive[2] == 1'b1, "R5 ch3 at wrap", int'(drive[2]), 1);
        for (int i = 0; i < 16; i++) duty_m[i] = shadow_m[i];
        measure_all("R5 after wrap");
    endtask

    task automatic t_enable();
        wr(8'h02, 8'hFE); en_m[7:0] = 8'hFE;
        wr(8'h01, 8'h7F); en_m[15:8] = 8'h7F;
        measure_all("R6 masked");
        wr(8'h02, 8'hFF); en_m[7:0] = 8'hFF;
        wr(8'h01, 8'hFF); en_m[15:8] = 8'hFF;
        measure_all("R6 restored");
    endtask

    task automatic t_sw();
        wr(8'h00, 8'h7F); run_m = 1'b0;
        measure_all("R7 sw off");
        wr(8'h00, 8'h80); run_m = 1'b1;
        measure_all("R7 resumed");
    endtask

    task automatic t_hw();
        @(negedge clk); shutdown_n = 1'b0; hw_m = 1'b0;
        measure_all("R8 hw off");
        shutdown_n = 1'b1; hw_m = 1'b1;
        measure_all("R8 resumed");
    endtask

    task automatic t_io();
        wr(8'h04, 8'h81); own_m = 8'h81;
        measure_all("R9 io owned");
        wr(8'h04, 8'h00); own_m = 8'h00;
        measure_all("R9 io released");
    endtask

    task automatic t_ignore();
        wr_duty(1, 8'h33);
        wr(8'h03, 8'h00);
        wr(8'h05, 8'hFF);
        wr(8'h0F, 8'h55);
        wr(8'h20, 8'h77);
        wr(8'hB1, 8'h01);
        wr(8'hAF, 8'h00);
        measure_all("R10 ignored");
        do_update(8'h01);
        measure_all("R10 R4 later update");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin duty_m[i] = 0; shadow_m[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_duty_map();
        t_shadow();
        t_wrap();
        t_enable();
        t_sw();
        t_hw();
        t_io();
        t_ignore();
        finish_run();
    end

endmodule